// File: doc/BRIEF.md
# Hashed Timer Calendar with Tick-Shift Insertion

The block holds a set of pending one-shot timers for a pacing engine. Each timer is filed by its absolute expiration time in one of four independent hash ways, one bucket per way per key. A free-running tick counter gives the present time. On every tick the block hashes the present time into all four ways. Each stored entry whose key equals that time is reported on its own output lane, together with its identifier and action code, and its bucket is freed.

A start request carries a relative interval, an identifier and an action code. The block adds the interval to the present tick and probes the four candidate buckets of that key. If none is free, it does not evict anything. It moves the key one tick later and probes all four ways again, and it repeats this until it finds a free bucket. Identical expiration times are therefore always placed, at the cost of a small delay in firing.

While an insertion is probing, a busy flag holds off further requests. A stop request removes every stored entry that carries a given identifier. If time overtakes a key that is still being probed, the timer is not stored. It is reported at once on a fifth lane reserved for that case.

Top module: `timer_calendar`

## Requirements
- R1: While reset is held, `exp_valid` is all zero, `busy` is low and `now_tick` is zero. Once reset is released, `now_tick` grows by exactly one on every clock.
- R2: A start request is accepted on a rising edge where `start_valid` is high and `busy` is low. If `now_tick` was N at that edge, the key is N + `start_interval`. A stored timer with key K pulses its lane of `exp_valid` for one cycle, with its identifier and action on that lane's field of `exp_id` and `exp_act`. The pulse is visible in the cycle where `now_tick` equals K + 1.
- R3: Each accepted timer is reported exactly once.
- R4: Up to four timers that share a key, on an otherwise empty table, are all reported in the same cycle, each on a different lane among lanes 0 to 3.
- R5: A fifth timer with that same key is not lost. Its key is pushed one tick later, and it is reported one cycle after the other four.
- R6: A stop request is accepted when `stop_valid` is high and `busy` is low. It removes every stored timer whose identifier equals `stop_id`, so none of them is reported. Timers with other identifiers are unaffected.
- R7: During probing, if the key is equal to or earlier than `now_tick`, the timer is reported on lane 4 in the next cycle and is not stored. A timer accepted with interval 0 or 1 at tick N is therefore reported on lane 4 with time N + 1. A timer accepted with interval 2 is stored and fires on a lane below 4.
- R8: `busy` is high in the cycle after a start is accepted. A start request held high while `busy` is high is not accepted until `busy` falls, and then it is accepted exactly once.
- R9: Expiry lookup and insertion probing proceed in the same cycle without delaying one another.
- R10: A stop accepted in the cycle where a matching stored timer expires wins: that timer is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_valid | input | 1 | Start request |
| start_interval | input | TIME_W | Ticks from now until expiry |
| start_id | input | ID_W | Timer identifier |
| start_act | input | ACT_W | Action code returned on expiry |
| stop_valid | input | 1 | Stop request |
| stop_id | input | ID_W | Identifier to remove |
| busy | output | 1 | Insertion probing; start and stop are held off |
| now_tick | output | TIME_W | Present tick count |
| exp_valid | output | 5 | One-cycle expiry strobe per lane (lanes 0-3 ways, lane 4 late bypass) |
| exp_id | output | 5*ID_W | Identifier per lane, lane L at bits [L*ID_W +: ID_W] |
| exp_act | output | 5*ACT_W | Action per lane, lane L at bits [L*ACT_W +: ACT_W] |

## Verification
The properties assume that every interval stays below half the tick range, so that a key is never mistaken for one in the past after the counter wraps. They also assume that the table never fills completely, so every probe ends in a free bucket or in the late path. The stop-priority property further assumes that lanes 0 to 3 carry only stored entries. The directed stimulus uses intervals of at most a few dozen ticks, never holds more than five pending timers, and lets each scenario's timers drain before the next scenario begins. This keeps the load well inside these limits.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int CAL_WAYS  = 4;
  localparam int CAL_LANES = CAL_WAYS + 1;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_PROBE = 1'b1
  } probe_st_t;
endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/cal_way.sv
// One hash way: one bucket per row, row chosen by a way-specific fold of the key.
module cal_way #(
  parameter int TIME_W  = 16,
  parameter int ID_W    = 8,
  parameter int ACT_W   = 4,
  parameter int ROW_W   = 4,
  parameter int WAY_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now,
  input  logic [TIME_W-1:0] probe_key,
  output logic              free,
  input  logic              ins_we,
  input  logic [ID_W-1:0]   ins_id,
  input  logic [ACT_W-1:0]  ins_act,
  input  logic              stop_en,
  input  logic [ID_W-1:0]   stop_id,
  output logic              hit,
  output logic [ID_W-1:0]   hit_id,
  output logic [ACT_W-1:0]  hit_act
);
  localparam int ROWS   = 1 << ROW_W;
  localparam int CHUNKS = TIME_W / ROW_W;
  localparam int ROT    = WAY_IDX % ROW_W;
  localparam logic [ROW_W-1:0] SALT = ROW_W'(WAY_IDX * 5 + 3);

  function automatic logic [ROW_W-1:0] row_of(input logic [TIME_W-1:0] k);
    logic [2*TIME_W-1:0] dbl;
    logic [TIME_W-1:0]   r;
    logic [ROW_W-1:0]    acc;
    dbl = {k, k};
    r   = dbl[TIME_W-ROT +: TIME_W];
    acc = SALT;
    for (int i = 0; i < CHUNKS; i++) acc = acc ^ r[i*ROW_W +: ROW_W];
    return acc;
  endfunction

  logic [ROWS-1:0]   vld_q, vld_d;
  logic [TIME_W-1:0] key_q [ROWS];
  logic [ID_W-1:0]   id_q  [ROWS];
  logic [ACT_W-1:0]  act_q [ROWS];

  logic [ROW_W-1:0] exp_row, ins_row;
  logic             match;

  assign exp_row = row_of(now);
  assign ins_row = row_of(probe_key);
  assign free    = !vld_q[ins_row];
  assign match   = vld_q[exp_row] && (key_q[exp_row] == now);
  // R10: a stop of the same identifier suppresses the report
  assign hit     = match && !(stop_en && (id_q[exp_row] == stop_id));
  assign hit_id  = id_q[exp_row];
  assign hit_act = act_q[exp_row];

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      vld_d[r] = vld_q[r];
      if (stop_en && (id_q[r] == stop_id))       vld_d[r] = 1'b0; // R6
      if (match && (ROW_W'(r) == exp_row))       vld_d[r] = 1'b0; // R3
      if (ins_we && (ROW_W'(r) == ins_row))      vld_d[r] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (ins_we) begin
      key_q[ins_row] <= probe_key;
      id_q[ins_row]  <= ins_id;
      act_q[ins_row] <= ins_act;
    end
  end
endmodule

// File: rtl/cal_prober.sv
// Insertion engine: compute key, probe all ways, shift one tick on a full set.
module cal_prober
  import cal_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int ID_W   = 8,
  parameter int ACT_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TIME_W-1:0]   now,
  input  logic                start_valid,
  input  logic [TIME_W-1:0]   start_interval,
  input  logic [ID_W-1:0]     start_id,
  input  logic [ACT_W-1:0]    start_act,
  input  logic [CAL_WAYS-1:0] way_free,
  output logic                busy,
  output logic [TIME_W-1:0]   probe_key,
  output logic [CAL_WAYS-1:0] ins_we,
  output logic [ID_W-1:0]     ent_id,
  output logic [ACT_W-1:0]    ent_act,
  output logic                late_fire
);
  probe_st_t         st_q, st_d;
  logic [TIME_W-1:0] key_q, key_d, diff;
  logic [ID_W-1:0]   id_q;
  logic [ACT_W-1:0]  act_q;
  logic              load_en, key_en, late;

  assign diff = key_q - now;
  assign late = diff[TIME_W-1] || (diff == '0); // R7

  always_comb begin
    st_d      = st_q;
    key_d     = key_q;
    load_en   = 1'b0;
    key_en    = 1'b0;
    ins_we    = '0;
    late_fire = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_valid) begin
          load_en = 1'b1;
          key_en  = 1'b1;
          key_d   = now + start_interval; // R2
          st_d    = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (late) begin
          late_fire = 1'b1;
          st_d      = ST_IDLE;
        end else if (|way_free) begin
          ins_we = way_free & (~way_free + 1'b1);
          st_d   = ST_IDLE;
        end else begin
          key_en = 1'b1;
          key_d  = key_q + 1'b1; // R5
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (key_en) key_q <= key_d;
    if (load_en) begin
      id_q  <= start_id;
      act_q <= start_act;
    end
  end

  assign busy      = (st_q == ST_PROBE); // R8
  assign probe_key = key_q;
  assign ent_id    = id_q;
  assign ent_act   = act_q;
endmodule

// File: rtl/timer_calendar.sv
module timer_calendar
  import cal_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int ID_W   = 8,
  parameter int ACT_W  = 4,
  parameter int ROW_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_valid,
  input  logic [TIME_W-1:0]          start_interval,
  input  logic [ID_W-1:0]            start_id,
  input  logic [ACT_W-1:0]           start_act,
  input  logic                       stop_valid,
  input  logic [ID_W-1:0]            stop_id,
  output logic                       busy,
  output logic [TIME_W-1:0]          now_tick,
  output logic [CAL_LANES-1:0]       exp_valid,
  output logic [CAL_LANES*ID_W-1:0]  exp_id,
  output logic [CAL_LANES*ACT_W-1:0] exp_act
);
  localparam int LANES = CAL_LANES;

  logic                rst_sync_n;
  logic [TIME_W-1:0]   now_q, now_d;
  logic [CAL_WAYS-1:0] way_free, way_hit, ins_we;
  logic [ID_W-1:0]     hit_id  [CAL_WAYS];
  logic [ACT_W-1:0]    hit_act [CAL_WAYS];
  logic [TIME_W-1:0]   probe_key;
  logic [ID_W-1:0]     ent_id;
  logic [ACT_W-1:0]    ent_act;
  logic                late_fire, stop_en;

  logic [LANES-1:0]       ev_d;
  logic [LANES*ID_W-1:0]  eid_d;
  logic [LANES*ACT_W-1:0] eact_d;

  cal_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // R1: free-running tick counter
  assign now_d = now_q + 1'b1;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) now_q <= '0;
    else             now_q <= now_d;
  end
  assign now_tick = now_q;

  assign stop_en = stop_valid && !busy; // R6

  cal_prober #(.TIME_W(TIME_W), .ID_W(ID_W), .ACT_W(ACT_W)) u_prober (
    .clk(clk), .rst_n(rst_sync_n), .now(now_q),
    .start_valid(start_valid), .start_interval(start_interval),
    .start_id(start_id), .start_act(start_act),
    .way_free(way_free), .busy(busy), .probe_key(probe_key),
    .ins_we(ins_we), .ent_id(ent_id), .ent_act(ent_act),
    .late_fire(late_fire)
  );

  // R9: each way has an expiry port on now and a probe port on probe_key
  for (genvar w = 0; w < CAL_WAYS; w++) begin : g_way
    cal_way #(
      .TIME_W(TIME_W), .ID_W(ID_W), .ACT_W(ACT_W),
      .ROW_W(ROW_W), .WAY_IDX(w)
    ) u_way (
      .clk(clk), .rst_n(rst_sync_n), .now(now_q), .probe_key(probe_key),
      .free(way_free[w]), .ins_we(ins_we[w]), .ins_id(ent_id),
      .ins_act(ent_act), .stop_en(stop_en), .stop_id(stop_id),
      .hit(way_hit[w]), .hit_id(hit_id[w]), .hit_act(hit_act[w])
    );
  end

  always_comb begin
    for (int w = 0; w < CAL_WAYS; w++) begin
      ev_d[w]                  = way_hit[w]; // R4
      eid_d[w*ID_W +: ID_W]    = hit_id[w];
      eact_d[w*ACT_W +: ACT_W] = hit_act[w];
    end
    ev_d[CAL_WAYS]                     = late_fire; // R7
    eid_d[CAL_WAYS*ID_W +: ID_W]       = ent_id;
    eact_d[CAL_WAYS*ACT_W +: ACT_W]    = ent_act;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) exp_valid <= '0;
    else             exp_valid <= ev_d;
  end

  always_ff @(posedge clk) begin
    exp_id  <= eid_d;
    exp_act <= eact_d;
  end
endmodule

// File: rtl/timer_calendar_chk.sv
module timer_calendar_chk #(
  parameter int TIME_W = 16,
  parameter int ID_W   = 8,
  parameter int LANES  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_valid,
  input logic                  stop_valid,
  input logic [ID_W-1:0]       stop_id,
  input logic                  busy,
  input logic [TIME_W-1:0]     now_tick,
  input logic [LANES-1:0]      exp_valid,
  input logic [LANES*ID_W-1:0] exp_id
);
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (now_tick == $past(now_tick) + 1'b1))
    else $error("tick counter skipped"); // R1

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !busy) |=> busy)
    else $error("busy not raised after accept"); // R8

  AST_LATE_FROM_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    exp_valid[LANES-1] |-> $past(busy))
    else $error("late lane without probing"); // R7

  for (genvar w = 0; w < LANES - 1; w++) begin : g_stop
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_valid && !busy) |=>
        !(exp_valid[w] && (exp_id[w*ID_W +: ID_W] == $past(stop_id))))
      else $error("stopped timer reported"); // R10
  end
endmodule

bind timer_calendar timer_calendar_chk #(
  .TIME_W(TIME_W), .ID_W(ID_W), .LANES(LANES)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start_valid(start_valid),
  .stop_valid(stop_valid), .stop_id(stop_id), .busy(busy),
  .now_tick(now_tick), .exp_valid(exp_valid), .exp_id(exp_id)
);

// File: tb/tb_timer_calendar.sv
module tb_timer_calendar;
  localparam int TW = 16, IW = 8, AW = 4, LN = 5;

  logic clk, rst_n, start_valid, stop_valid, busy;
  logic [TW-1:0] start_interval, now_tick;
  logic [IW-1:0] start_id, stop_id;
  logic [AW-1:0] start_act;
  logic [LN-1:0] exp_valid;
  logic [LN*IW-1:0] exp_id;
  logic [LN*AW-1:0] exp_act;

  timer_calendar dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
    .start_interval(start_interval), .start_id(start_id),
    .start_act(start_act), .stop_valid(stop_valid), .stop_id(stop_id),
    .busy(busy), .now_tick(now_tick), .exp_valid(exp_valid),
    .exp_id(exp_id), .exp_act(exp_act)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int ev_n = 0, base = 0;
  int ev_id [0:255];
  int ev_t  [0:255];
  int ev_ln [0:255];
  int ev_ac [0:255];

  // expiry log: time recorded as the tick of the lookup (now_tick - 1)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < LN; l++) begin
        if (exp_valid[l] && ev_n < 256) begin
          ev_id[ev_n] = int'(exp_id[l*IW +: IW]);
          ev_ac[ev_n] = int'(exp_act[l*AW +: AW]);
          ev_t[ev_n]  = int'(now_tick) - 1;
          ev_ln[ev_n] = l;
          ev_n = ev_n + 1;
        end
      end
    end
  end

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cnt_id(input int id);
    int c = 0;
    for (int i = base; i < ev_n; i++) if (ev_id[i] == id) c++;
    return c;
  endfunction

  function automatic int idx_id(input int id);
    for (int i = base; i < ev_n; i++) if (ev_id[i] == id) return i;
    return 0;
  endfunction

  task automatic start_timer(input int id, input int act, input int ivl, output int acc);
    while (busy) @(negedge clk);
    start_valid = 1'b1; start_interval = TW'(ivl);
    start_id = IW'(id); start_act = AW'(act); acc = int'(now_tick);
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic start_at(input int id, input int act, input int tgt);
    int acc;
    while (busy) @(negedge clk);
    start_timer(id, act, tgt - int'(now_tick), acc);
  endtask

  task automatic do_stop(input int id);
    while (busy) @(negedge clk);
    stop_valid = 1'b1; stop_id = IW'(id);
    @(negedge clk);
    stop_valid = 1'b0;
  endtask

  task automatic t_reset;
    int a;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1 exp_valid in reset", int'(exp_valid), 0);
    chk_eq("R1 busy in reset", int'(busy), 0);
    chk_eq("R1 now_tick in reset", int'(now_tick), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    a = int'(now_tick);
    @(negedge clk);
    chk_eq("R1 tick step", int'(now_tick), a + 1);
  endtask

  task automatic t_single;
    int acc, i;
    base = ev_n;
    start_timer(8'h11, 3, 20, acc);
    repeat (26) @(negedge clk);
    chk_eq("R3 single fires once", cnt_id(8'h11), 1);
    i = idx_id(8'h11);
    chk_eq("R2 fire time", ev_t[i], acc + 20);
    chk_eq("R2 action code", ev_ac[i], 3);
    chk_eq("R2 stored lane below 4", int'(ev_ln[i] < 4), 1);
  endtask

  task automatic t_same_key;
    int tgt, mask;
    base = ev_n;
    tgt = int'(now_tick) + 40;
    for (int k = 0; k < 5; k++) start_at(8'h21 + k, k, tgt);
    while (int'(now_tick) < tgt + 6) @(negedge clk);
    mask = 0;
    for (int k = 0; k < 4; k++) begin
      chk_eq("R4 shared key fires once", cnt_id(8'h21 + k), 1);
      chk_eq("R4 shared key time", ev_t[idx_id(8'h21 + k)], tgt);
      mask = mask | (1 << ev_ln[idx_id(8'h21 + k)]);
    end
    chk_eq("R4 four distinct lanes", mask, 15);
    chk_eq("R5 fifth fires once", cnt_id(8'h25), 1);
    chk_eq("R5 fifth shifted one tick", ev_t[idx_id(8'h25)], tgt + 1);
  endtask

  task automatic t_stop;
    int a1, a2;
    base = ev_n;
    start_timer(8'h31, 1, 30, a1);
    start_timer(8'h32, 2, 30, a2);
    repeat (5) @(negedge clk);
    do_stop(8'h31);
    repeat (35) @(negedge clk);
    chk_eq("R6 stopped timer silent", cnt_id(8'h31), 0);
    chk_eq("R6 other timer kept", cnt_id(8'h32), 1);
    chk_eq("R6 other timer time", ev_t[idx_id(8'h32)], a2 + 30);
  endtask

  task automatic t_stop_race;
    int acc, k;
    base = ev_n;
    start_timer(8'h41, 4, 20, acc);
    k = acc + 20;
    while (int'(now_tick) != k) @(negedge clk);
    do_stop(8'h41);
    repeat (6) @(negedge clk);
    chk_eq("R10 stop beats expiry", cnt_id(8'h41), 0);
  endtask

  task automatic t_late;
    int a0, a1, a2;
    base = ev_n;
    start_timer(8'h51, 5, 0, a0);
    start_timer(8'h52, 6, 1, a1);
    start_timer(8'h53, 7, 2, a2);
    repeat (8) @(negedge clk);
    chk_eq("R7 interval 0 lane", ev_ln[idx_id(8'h51)], 4);
    chk_eq("R7 interval 0 time", ev_t[idx_id(8'h51)], a0 + 1);
    chk_eq("R7 interval 0 action", ev_ac[idx_id(8'h51)], 5);
    chk_eq("R7 interval 1 lane", ev_ln[idx_id(8'h52)], 4);
    chk_eq("R7 interval 1 time", ev_t[idx_id(8'h52)], a1 + 1);
    chk_eq("R7 interval 2 stored", int'(ev_ln[idx_id(8'h53)] < 4), 1);
    chk_eq("R7 interval 2 time", ev_t[idx_id(8'h53)], a2 + 2);
    chk_eq("R3 late reported once", cnt_id(8'h51), 1);
  endtask

  task automatic t_backpressure;
    int a1, a2;
    base = ev_n;
    while (busy) @(negedge clk);
    start_valid = 1'b1; start_interval = 16'd30;
    start_id = 8'h61; start_act = 4'd1; a1 = int'(now_tick);
    @(negedge clk);
    chk_eq("R8 busy after accept", int'(busy), 1);
    start_id = 8'h62; start_act = 4'd2;
    @(negedge clk);
    chk_eq("R8 busy falls after probe", int'(busy), 0);
    a2 = int'(now_tick);
    @(negedge clk);
    start_valid = 1'b0;
    repeat (36) @(negedge clk);
    chk_eq("R8 first accepted once", cnt_id(8'h61), 1);
    chk_eq("R8 held request once", cnt_id(8'h62), 1);
    chk_eq("R8 first time", ev_t[idx_id(8'h61)], a1 + 30);
    chk_eq("R8 held time", ev_t[idx_id(8'h62)], a2 + 30);
  endtask

  task automatic t_overlap;
    int acc, a2, k;
    base = ev_n;
    start_timer(8'h71, 1, 10, acc);
    k = acc + 10;
    while (int'(now_tick) != k - 1) @(negedge clk);
    start_timer(8'h72, 2, 10, a2);
    repeat (16) @(negedge clk);
    chk_eq("R9 expiry during probe", ev_t[idx_id(8'h71)], k);
    chk_eq("R9 probe during expiry", ev_t[idx_id(8'h72)], a2 + 10);
    chk_eq("R9 both once", cnt_id(8'h71) + cnt_id(8'h72), 2);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    start_valid = 1'b0; stop_valid = 1'b0;
    start_interval = '0; start_id = '0; start_act = '0; stop_id = '0;
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_same_key();
    t_stop();
    t_stop_race();
    t_late();
    t_backpressure();
    t_overlap();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    summary();
    $finish;
  end
endmodule